// File: doc/BRIEF.md
# Serial Register File Responder

This block sits on the device side of a framed, bit-serial control link. One bit moves on each clock. A rising edge on the frame sync input marks bit 1 of a new frame. Within the first 64-bit subframe of each frame, the host sends three fields: a 4-bit register address, a read/write flag and a 16-bit data word. The responder holds sixteen 16-bit registers that reset to zero.

The responder acts on the flag as soon as it arrives, in the middle of the frame. It looks up the addressed register and shifts that register's contents back to the host in the same frame. This happens for reads and for writes alike. A write commits the received data only at the very end of the subframe. As a result, a write frame returns the register's old contents, and the new value appears in the next frame. If a frame is cut short by a new sync edge before that final bit, it writes nothing.

A combinational debug port reads any register directly, without using the serial path.

Top module: `srf_responder`

## Requirements
- R1: After reset, all sixteen registers read zero and `sdo_o` is low.
- R2: Bit positions count from 1, where bit 1 is the bit that arrives with the sync rising edge. The address occupies bits 37..40, MSB first. The read/write flag is at bit 41, where 1 means write and 0 means read. The data occupies bits 42..57, MSB first.
- R3: In every frame that reaches bit 41, the addressed register's value is shifted out on `sdo_o` during bits 42..57 of the same frame, MSB first.
- R4: A write updates the addressed register at the clock edge that closes bit 65. The same frame's readback therefore carries the previous contents.
- R5: In the frame that follows a write, including one that starts back-to-back, a read or write of the same address returns the newly written value.
- R6: `sdo_o` is low during bits 2..41 and during bit 58 onward of a frame.
- R7: A sync rising edge restarts the count at bit 1. A write frame that is interrupted by a new sync edge before bit 65 leaves the registers unchanged.
- R8: Bits 1..36 and 58..65 have no effect on the address, flag, data or readback.
- R9: `dbg_data_o` shows the register selected by `dbg_addr_i` in the same cycle.
- R10: A read frame leaves the addressed register unchanged, whatever its data field holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock; one serial bit per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | Frame sync; a rising edge marks bit 1 |
| sdi_i | input | 1 | Serial data from the host |
| sdo_o | output | 1 | Serial readback to the host |
| dbg_addr_i | input | 4 | Debug read address |
| dbg_data_o | output | 16 | Debug read data |

## Verification
Inputs change on falling edges. The readback bit for position b sits on `sdo_o` for the whole period of bit b. That period begins at the rising edge that closes bit b-1, so the bench samples it on the falling edge before it drives bit b. The write lands on the edge that closes bit 65. The bench therefore samples the debug port once on the falling edge before that edge, expecting the old value, and once on the falling edge after it, expecting the new value. The next frame's readback is due in bits 42..57 of that frame, whether a gap separates the frames or not.

// File: rtl/srf_pkg.sv
package srf_pkg;
  parameter int SRF_ADDR_W   = 4;
  parameter int SRF_DATA_W   = 16;
  parameter int SRF_ADDR_POS = 37;  // first address bit, 1-based
  parameter int SRF_SUB_BITS = 64;
endpackage

// File: rtl/srf_frame_rx.sv
module srf_frame_rx #(
  parameter int ADDR_W   = srf_pkg::SRF_ADDR_W,
  parameter int DATA_W   = srf_pkg::SRF_DATA_W,
  parameter int ADDR_POS = srf_pkg::SRF_ADDR_POS,
  parameter int SUB_BITS = srf_pkg::SRF_SUB_BITS,
  localparam int RW_POS  = ADDR_POS + ADDR_W,
  localparam int DLAST   = RW_POS + DATA_W,
  localparam int COMMIT  = SUB_BITS + 1,
  localparam int DONE    = COMMIT + 1,
  localparam int CNT_W   = $clog2(DONE + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  input  logic              sdi_i,
  output logic              rd_stb_o,
  output logic              wr_stb_o,
  output logic              tx_shift_o,
  output logic              tx_en_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  localparam logic [CNT_W-1:0] A_LO  = CNT_W'(ADDR_POS);
  localparam logic [CNT_W-1:0] A_HI  = CNT_W'(RW_POS - 1);
  localparam logic [CNT_W-1:0] RW_I  = CNT_W'(RW_POS);
  localparam logic [CNT_W-1:0] D_LO  = CNT_W'(RW_POS + 1);
  localparam logic [CNT_W-1:0] D_HI  = CNT_W'(DLAST);
  localparam logic [CNT_W-1:0] CM_I  = CNT_W'(COMMIT);
  localparam logic [CNT_W-1:0] DN_I  = CNT_W'(DONE);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  logic              frame_q, rise;
  logic [CNT_W-1:0]  cnt_q, cur_idx;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              rw_q, rd_seen_q;

  assign rise = frame_i & ~frame_q;

  // index of the bit arriving in this cycle; 0 = idle, DONE = past commit
  always_comb begin
    if (rise)                             cur_idx = ONE;
    else if (cnt_q == '0 || cnt_q == DN_I) cur_idx = cnt_q;
    else                                  cur_idx = cnt_q + ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q   <= 1'b0;
      cnt_q     <= '0;
      addr_q    <= '0;
      data_q    <= '0;
      rw_q      <= 1'b0;
      rd_seen_q <= 1'b0;
    end else begin
      frame_q <= frame_i;
      cnt_q   <= cur_idx;
      if (cur_idx >= A_LO && cur_idx <= A_HI) addr_q <= {addr_q[ADDR_W-2:0], sdi_i};
      if (cur_idx == RW_I) rw_q <= sdi_i;
      if (cur_idx >= D_LO && cur_idx <= D_HI) data_q <= {data_q[DATA_W-2:0], sdi_i};
      if (cur_idx == RW_I) rd_seen_q <= 1'b1;
      else if (rise)       rd_seen_q <= 1'b0;
    end
  end

  assign rd_stb_o   = (cur_idx == RW_I);
  assign wr_stb_o   = (cur_idx == CM_I) && rw_q;
  assign tx_shift_o = (cur_idx >= D_LO) && (cur_idx <= D_HI);
  assign tx_en_o    = (cnt_q >= RW_I) && (cnt_q < D_HI);
  assign addr_o     = addr_q;
  assign data_o     = data_q;

  AST_WR_AFTER_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |-> rd_seen_q); // R4
  AST_NO_WR_ON_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |-> !wr_stb_o); // R7
endmodule

// File: rtl/srf_reg_bank.sv
module srf_reg_bank #(
  parameter int ADDR_W = srf_pkg::SRF_ADDR_W,
  parameter int DATA_W = srf_pkg::SRF_DATA_W,
  localparam int NREGS = 2 ** ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [ADDR_W-1:0] dbg_addr_i,
  output logic [DATA_W-1:0] dbg_data_o
);
  logic [DATA_W-1:0] mem_q [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  mem_q[g] <= '0;
      else if (we_i && waddr_i == ADDR_W'(g))       mem_q[g] <= wdata_i;
    end
  end

  assign rdata_o    = mem_q[raddr_i];
  assign dbg_data_o = mem_q[dbg_addr_i];

  AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (mem_q[$past(waddr_i)] == $past(wdata_i))); // R4
endmodule

// File: rtl/srf_tx_shift.sv
module srf_tx_shift #(
  parameter int DATA_W = srf_pkg::SRF_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              shift_i,
  input  logic              en_i,
  output logic              sdo_o
);
  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (load_i)  sh_q <= din_i;
    else if (shift_i) sh_q <= {sh_q[DATA_W-2:0], 1'b0};
  end

  assign sdo_o = en_i & sh_q[DATA_W-1];

  AST_TX_LOADED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (sh_q == $past(din_i))); // R3
endmodule

// File: rtl/srf_responder.sv
module srf_responder #(
  parameter int ADDR_W   = srf_pkg::SRF_ADDR_W,
  parameter int DATA_W   = srf_pkg::SRF_DATA_W,
  parameter int ADDR_POS = srf_pkg::SRF_ADDR_POS,
  parameter int SUB_BITS = srf_pkg::SRF_SUB_BITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  input  logic [ADDR_W-1:0] dbg_addr_i,
  output logic [DATA_W-1:0] dbg_data_o
);
  logic              rd_stb, wr_stb, tx_shift, tx_en;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata, rdata;

  srf_frame_rx #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ADDR_POS(ADDR_POS), .SUB_BITS(SUB_BITS)
  ) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_i(frame_i), .sdi_i(sdi_i),
    .rd_stb_o(rd_stb), .wr_stb_o(wr_stb), .tx_shift_o(tx_shift), .tx_en_o(tx_en),
    .addr_o(addr), .data_o(wdata)
  );

  srf_reg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr_stb), .waddr_i(addr), .wdata_i(wdata),
    .raddr_i(addr), .rdata_o(rdata), .dbg_addr_i(dbg_addr_i), .dbg_data_o(dbg_data_o)
  );

  srf_tx_shift #(.DATA_W(DATA_W)) u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(rd_stb), .din_i(rdata),
    .shift_i(tx_shift), .en_i(tx_en), .sdo_o(sdo_o)
  );

  AST_RD_WR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_stb && wr_stb)); // R4
  AST_TX_QUIET_ON_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stb |-> !sdo_o); // R6
endmodule

// File: tb/srf_responder_bench.sv
module srf_responder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame = 1'b0;
  logic        sdi = 1'b0;
  logic        sdo;
  logic [3:0]  dbg_addr = '0;
  logic [15:0] dbg_data;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  srf_responder u_srf_responder (
    .clk_i(clk), .rst_ni(rst_n), .frame_i(frame), .sdi_i(sdi), .sdo_o(sdo),
    .dbg_addr_i(dbg_addr), .dbg_data_o(dbg_data)
  );

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one frame of len bits; rb = readback bits 42..57, pre = debug value before bit-65 edge
  task automatic run_frame(input logic rw, input logic [3:0] a, input logic [15:0] d,
                           input int len, input logic junk,
                           output logic [15:0] rb, output logic [15:0] pre, output bit quiet);
    rb = '0; pre = '0; quiet = 1'b1; dbg_addr = a;
    for (int b = 1; b <= len; b++) begin
      @(negedge clk);
      if (b >= 42 && b <= 57) rb[57-b] = sdo;
      else if (b >= 2 && sdo) quiet = 1'b0;
      if (b == 65) pre = dbg_data;
      frame = (b == 1);
      if (b >= 37 && b <= 40)      sdi = a[40-b];
      else if (b == 41)            sdi = rw;
      else if (b >= 42 && b <= 57) sdi = d[57-b];
      else                         sdi = junk & b[0];
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      frame = 1'b0; sdi = 1'b0;
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(sdo == 1'b0, "R1 sdo", {15'd0, sdo}, 16'h0);
    for (int r = 0; r < 16; r++) begin
      dbg_addr = 4'(r);
      #0.1;
      check(dbg_data == 16'h0, "R1/R9 reset reg", dbg_data, 16'h0);
    end
  endtask

  task automatic t_write_read;
    logic [15:0] rb, pre; bit q;
    run_frame(1'b1, 4'd5, 16'hA5C3, 65, 1'b1, rb, pre, q);
    check(rb == 16'h0, "R4 write returns old", rb, 16'h0);
    check(pre == 16'h0, "R4 not before bit 65", pre, 16'h0);
    check(q, "R6 quiet outside window", {15'd0, q}, 16'h1);
    idle(1);
    check(dbg_data == 16'hA5C3, "R4/R9 committed", dbg_data, 16'hA5C3);
    idle(3);
    run_frame(1'b0, 4'd5, 16'hFFFF, 65, 1'b1, rb, pre, q);
    check(rb == 16'hA5C3, "R3/R5 read new value", rb, 16'hA5C3);
    check(q, "R6 quiet on read", {15'd0, q}, 16'h1);
    idle(1);
    check(dbg_data == 16'hA5C3, "R10 read leaves reg", dbg_data, 16'hA5C3);
  endtask

  task automatic t_overwrite;
    logic [15:0] rb, pre; bit q;
    run_frame(1'b1, 4'd5, 16'h1234, 65, 1'b0, rb, pre, q);
    check(rb == 16'hA5C3, "R4 overwrite returns previous", rb, 16'hA5C3);
    check(pre == 16'hA5C3, "R4 old held through bit 65", pre, 16'hA5C3);
    idle(1);
    check(dbg_data == 16'h1234, "R4 overwrite lands", dbg_data, 16'h1234);
  endtask

  task automatic t_back_to_back;
    logic [15:0] rb, pre; bit q;
    run_frame(1'b1, 4'd15, 16'h8001, 65, 1'b1, rb, pre, q);
    run_frame(1'b1, 4'd15, 16'h7FFE, 65, 1'b1, rb, pre, q);
    check(rb == 16'h8001, "R5 back-to-back returns new", rb, 16'h8001);
    run_frame(1'b0, 4'd0, 16'h0, 65, 1'b1, rb, pre, q);
    check(rb == 16'h0, "R2 address decode reg0", rb, 16'h0);
    run_frame(1'b0, 4'd15, 16'h0, 65, 1'b0, rb, pre, q);
    check(rb == 16'h7FFE, "R2/R5 reg15", rb, 16'h7FFE);
    idle(2);
  endtask

  task automatic t_short_frame;
    logic [15:0] rb, pre; bit q;
    run_frame(1'b1, 4'd3, 16'hBEEF, 50, 1'b0, rb, pre, q);
    run_frame(1'b0, 4'd3, 16'h0, 65, 1'b0, rb, pre, q);
    check(rb == 16'h0, "R7 short frame no write", rb, 16'h0);
    idle(1);
    check(dbg_data == 16'h0, "R7 reg3 untouched", dbg_data, 16'h0);
  endtask

  task automatic t_junk;
    logic [15:0] rb, pre; bit q;
    run_frame(1'b1, 4'd9, 16'h0F0F, 65, 1'b1, rb, pre, q);
    run_frame(1'b0, 4'd9, 16'hAAAA, 65, 1'b1, rb, pre, q);
    check(rb == 16'h0F0F, "R8 junk bits ignored", rb, 16'h0F0F);
    idle(1);
    check(dbg_data == 16'h0F0F, "R8/R10 reg9", dbg_data, 16'h0F0F);
    dbg_addr = 4'd5;
    #0.1;
    check(dbg_data == 16'h1234, "R8 reg5 unaffected", dbg_data, 16'h1234);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write_read();
    t_overwrite();
    t_back_to_back();
    t_short_frame();
    t_junk();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule